// File: doc/BRIEF.md
# LCD Controller Interrupt Status and Enable Unit

This unit gathers the four event signals a display controller produces (pixel FIFO underrun, frame base address update, vertical compare and bus error) and holds each in a sticky pending bit. A mask register selects which pending bits may reach the interrupt outputs. There is one output line per source and one combined line that is high while any unmasked source is pending.

Software reaches the unit through a small synchronous register port. It writes the mask at one offset and reads pending bits back at a second offset. Writing a one at a third offset acknowledges the matching pending bit. Events are sampled on every rising clock edge. A source that stays high keeps its pending bit set for as long as it is high.

Top module: `lcd_irq_unit`

## Requirements
- R1: After synchronous reset the mask register, the pending register and every interrupt output are zero.
- R2: A high level on `evt_i[k]` at a rising edge sets pending bit k from that edge on. The bit stays set until a clear write removes it. Source k is 0 underrun, 1 base update, 2 vertical compare, 3 bus error.
- R3: A read at offset 0x10 returns the raw pending bits in `rdata[3:0]` with upper bits zero, whatever the mask holds.
- R4: A write at offset 0x0C clears exactly the pending bits whose positions are one in `wdata[3:0]`. Every other pending bit keeps its value.
- R5: When a clear write and an event hit the same bit in the same cycle, the event wins and the bit is set after the edge.
- R6: `irq_line[k]` is high exactly when pending bit k and mask bit k are both one.
- R7: `irq_any` is high exactly when at least one `irq_line` bit is high.
- R8: A write at offset 0x08 loads `wdata[3:0]` into the mask. The outputs follow the new mask from the edge that takes the write. A read at 0x08 returns the mask.
- R9: A write at offset 0x10 or at any unused offset changes neither register. A read at the clear offset 0x0C, or at an unused offset, returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 4 | Event levels, one per source |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W (8) | Byte offset of the access |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data for `reg_addr`, combinational |
| irq_line | output | 4 | Masked per-source interrupt lines |
| irq_any | output | 1 | OR of all masked interrupt lines |

## Verification
The checker assumes that `evt_i`, `reg_wr`, `reg_addr` and `reg_wdata` carry known values at every rising edge after reset. It also assumes that a write of any kind lasts exactly one cycle of `reg_wr` being high. The bench changes every input only on the falling edge. Random cycles mix sparse event pulses with writes to the mask, clear, status and unused offsets. Directed cycles place a clear and an event on the same bit in one cycle, so the overlap rule is exercised on purpose rather than by chance.

// File: rtl/lcd_irq_pkg.sv
package lcd_irq_pkg;

    localparam int SRC_N = 4;

    typedef enum logic [1:0] {
        SRC_UNDERRUN = 2'd0,
        SRC_BASE_UPD = 2'd1,
        SRC_VCMP     = 2'd2,
        SRC_BUS_ERR  = 2'd3
    } irq_src_e;

    typedef logic [SRC_N-1:0] src_vec_t;

    typedef enum logic [1:0] {
        RSEL_NONE   = 2'd0,
        RSEL_MASK   = 2'd1,
        RSEL_STATUS = 2'd2
    } rd_sel_e;

    typedef struct packed {
        logic     mask_we;
        logic     clr_we;
        src_vec_t bits;
    } reg_cmd_t;

    localparam int OFF_MASK   = 'h08;
    localparam int OFF_CLEAR  = 'h0C;
    localparam int OFF_STATUS = 'h10;

    function automatic src_vec_t pend_next(src_vec_t cur, src_vec_t clr, src_vec_t evt);
        return (cur & ~clr) | evt;
    endfunction

endpackage

// File: rtl/lcd_irq_decode.sv
module lcd_irq_decode
    import lcd_irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  src_vec_t          mask_q,
    input  src_vec_t          pend_q,
    output reg_cmd_t          cmd,
    output logic [DATA_W-1:0] reg_rdata
);
    localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFF_MASK);
    localparam logic [ADDR_W-1:0] A_CLEAR  = ADDR_W'(OFF_CLEAR);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFF_STATUS);

    rd_sel_e rsel;
    logic    unused_hi;

    assign unused_hi = ^reg_wdata[DATA_W-1:SRC_N];

    always_comb begin
        cmd.mask_we = reg_wr && (reg_addr == A_MASK);
        cmd.clr_we  = reg_wr && (reg_addr == A_CLEAR);
        cmd.bits    = reg_wdata[SRC_N-1:0];
    end

    always_comb begin
        if (reg_addr == A_MASK)        rsel = RSEL_MASK;
        else if (reg_addr == A_STATUS) rsel = RSEL_STATUS;
        else                           rsel = RSEL_NONE;
    end

    always_comb begin
        reg_rdata = '0;
        case (rsel)
            RSEL_MASK:   reg_rdata[SRC_N-1:0] = mask_q;
            RSEL_STATUS: reg_rdata[SRC_N-1:0] = pend_q;
            default:     reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/lcd_irq_pending.sv
module lcd_irq_pending
    import lcd_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t evt_i,
    input  reg_cmd_t cmd,
    output src_vec_t pend_q
);
    src_vec_t clr_mask;

    assign clr_mask = cmd.clr_we ? cmd.bits : '0;

    for (genvar k = 0; k < SRC_N; k++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                pend_q[k] <= 1'b0;
            end else begin
                pend_q[k] <= (pend_q[k] & ~clr_mask[k]) | evt_i[k];
            end
        end
    end
endmodule

// File: rtl/lcd_irq_mask.sv
module lcd_irq_mask
    import lcd_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  reg_cmd_t cmd,
    input  src_vec_t pend_q,
    output src_vec_t mask_q,
    output src_vec_t irq_line,
    output logic     irq_any
);
    always_ff @(posedge clk) begin
        if (rst)              mask_q <= '0;
        else if (cmd.mask_we) mask_q <= cmd.bits;
    end

    for (genvar k = 0; k < SRC_N; k++) begin : g_line
        assign irq_line[k] = pend_q[k] & mask_q[k];
    end

    assign irq_any = |irq_line;
endmodule

// File: rtl/lcd_irq_unit.sv
module lcd_irq_unit
    import lcd_irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        evt_i,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [3:0]        irq_line,
    output logic              irq_any
);
    reg_cmd_t cmd;
    src_vec_t stat_q;
    src_vec_t en_q;

    lcd_irq_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_decode (
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .mask_q    (en_q),
        .pend_q    (stat_q),
        .cmd       (cmd),
        .reg_rdata (reg_rdata)
    );

    lcd_irq_pending u_pending (
        .clk    (clk),
        .rst    (rst),
        .evt_i  (evt_i),
        .cmd    (cmd),
        .pend_q (stat_q)
    );

    lcd_irq_mask u_mask (
        .clk      (clk),
        .rst      (rst),
        .cmd      (cmd),
        .pend_q   (stat_q),
        .mask_q   (en_q),
        .irq_line (irq_line),
        .irq_any  (irq_any)
    );
endmodule

// File: rtl/lcd_irq_unit_chk.sv
module lcd_irq_unit_chk
    import lcd_irq_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [3:0]        evt_i,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [3:0]        stat_q,
    input logic [3:0]        en_q,
    input logic [3:0]        irq_line,
    input logic              irq_any
);
    logic [3:0] clr_req;
    logic       wr_mask, wr_other;

    assign clr_req  = (reg_wr && reg_addr == ADDR_W'(OFF_CLEAR)) ? reg_wdata[3:0] : 4'd0;
    assign wr_mask  = reg_wr && reg_addr == ADDR_W'(OFF_MASK);
    assign wr_other = reg_wr && reg_addr != ADDR_W'(OFF_MASK) && reg_addr != ADDR_W'(OFF_CLEAR);

    // R2, R5: an event always leaves its bit set
    assert_evt_sets_R2: assert property (@(posedge clk) disable iff (rst)
        (evt_i != 4'd0) |=> ((stat_q & $past(evt_i)) == $past(evt_i)));

    // R2: a pending bit only falls when a clear asked for it
    assert_sticky_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (($past(stat_q) & ~stat_q & ~$past(clr_req)) == 4'd0));

    // R4: cleared bits without a competing event are gone
    assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (clr_req != 4'd0 && evt_i == 4'd0) |=> ((stat_q & $past(clr_req)) == 4'd0));

    // R8: mask write loads the low data bits
    assert_mask_load_R8: assert property (@(posedge clk) disable iff (rst)
        wr_mask |=> (en_q == $past(reg_wdata[3:0])));

    // R9: writes elsewhere leave both registers alone
    assert_no_side_write_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_other && evt_i == 4'd0) |=> ($stable(stat_q) && $stable(en_q)));

    // R6: no line is raised for a masked or idle source
    assert_line_gated_R6: assert property (@(posedge clk) disable iff (rst)
        (irq_line & ~(stat_q & en_q)) == 4'd0);

    // R7: combined output agrees with the individual lines
    assert_any_R7: assert property (@(posedge clk) disable iff (rst)
        irq_any == ($countones(irq_line) != 0));
endmodule

bind lcd_irq_unit lcd_irq_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .evt_i     (evt_i),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .stat_q    (stat_q),
    .en_q      (en_q),
    .irq_line  (irq_line),
    .irq_any   (irq_any)
);

// File: tb/lcd_irq_unit_bench.sv
module lcd_irq_unit_bench;
    import lcd_irq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [3:0]        evt_i = '0;
    logic              reg_wr = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic [3:0]        irq_line;
    logic              irq_any;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [3:0] m_en = '0;
    logic [3:0] m_stat = '0;

    lcd_irq_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lcd_irq_unit (
        .clk(clk), .rst(rst), .evt_i(evt_i), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_line(irq_line), .irq_any(irq_any)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog: run did not complete, actual %0d cycles expected below 20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_stat(logic [3:0] cur, logic [3:0] clr, logic [3:0] evt);
        return (cur & ~clr) | evt;
    endfunction

    // one clock: drive at falling edge, update model at the rising edge, check outputs after it
    task automatic step(input logic [3:0] evt, input logic wr, input logic [7:0] addr, input logic [31:0] data);
        logic [3:0] clr;
        @(negedge clk);
        evt_i = evt; reg_wr = wr; reg_addr = addr; reg_wdata = data;
        @(posedge clk);
        #1;
        clr = (wr && addr == 8'h0C) ? data[3:0] : 4'd0;
        m_stat = exp_stat(m_stat, clr, evt);
        if (wr && addr == 8'h08) m_en = data[3:0];
        chk(irq_line == (m_stat & m_en), "R6 lines", {28'd0, irq_line}, {28'd0, m_stat & m_en});
        chk(irq_any == |(m_stat & m_en), "R7 combined", {31'd0, irq_any}, {31'd0, |(m_stat & m_en)});
    endtask

    task automatic rd(input logic [7:0] addr, input logic [31:0] exp, input string req);
        @(negedge clk);
        evt_i = '0; reg_wr = 1'b0; reg_addr = addr; reg_wdata = '0;
        #1;
        chk(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk(irq_line == 4'd0 && irq_any == 1'b0, "R1 outputs", {27'd0, irq_any, irq_line}, 32'd0);
        rd(8'h08, 32'd0, "R1 mask");
        rd(8'h10, 32'd0, "R1 status");

        // R3: raw status with mask clear (underrun and vertical compare)
        step(4'b0101, 1'b0, 8'h00, 32'd0);
        rd(8'h10, 32'h5, "R3 raw status unmasked");
        chk(irq_any == 1'b0, "R7 nothing enabled", {31'd0, irq_any}, 32'd0);

        // R8: enable underrun only
        step(4'b0000, 1'b1, 8'h08, 32'hFFFF_FFF1);
        chk(irq_line == 4'b0001, "R8 line follows mask", {28'd0, irq_line}, 32'h1);
        rd(8'h08, 32'h1, "R8 mask readback");

        // R4: clear vertical compare only
        step(4'b0000, 1'b1, 8'h0C, 32'h4);
        rd(8'h10, 32'h1, "R4 partial clear");

        // R5: clear and event on underrun in one cycle
        step(4'b0001, 1'b1, 8'h0C, 32'h1);
        rd(8'h10, 32'h1, "R5 event wins over clear");

        // R9: writes to status and unused offsets are ignored
        step(4'b0000, 1'b1, 8'h10, 32'hF);
        step(4'b0000, 1'b1, 8'h20, 32'hF);
        rd(8'h10, 32'h1, "R9 status unchanged");
        rd(8'h08, 32'h1, "R9 mask unchanged");
        rd(8'h0C, 32'd0, "R9 clear reads zero");
        rd(8'h44, 32'd0, "R9 unused reads zero");

        // R2: sticky through idle cycles, bus error source
        step(4'b1000, 1'b0, 8'h00, 32'd0);
        repeat (4) step(4'b0000, 1'b0, 8'h00, 32'd0);
        rd(8'h10, 32'h9, "R2 sticky bits");
        step(4'b0000, 1'b1, 8'h08, 32'h8);
        chk(irq_line == 4'b1000 && irq_any, "R8 bus error line", {27'd0, irq_any, irq_line}, 32'h18);

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [3:0] ev;
            int op;
            logic [7:0] a;
            ev = (($urandom % 4) == 0) ? 4'($urandom) : 4'd0;
            op = $urandom % 5;
            case (op)
                0: a = 8'h08;
                1: a = 8'h0C;
                2: a = 8'h10;
                3: a = 8'h04;
                default: a = 8'h00;
            endcase
            step(ev, op != 4, a, $urandom);
            if (i % 16 == 0) begin
                rd(8'h10, {28'd0, m_stat}, "R3 random status");
                rd(8'h08, {28'd0, m_en}, "R8 random mask");
            end
        end

        // R1: reset mid-run
        @(negedge clk);
        rst = 1'b1; evt_i = '0; reg_wr = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_en = '0; m_stat = '0;
        rd(8'h10, 32'd0, "R1 status after reset");
        rd(8'h08, 32'd0, "R1 mask after reset");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule